// File: doc/BRIEF.md
# Parallel EPROM Read Sequencer

This block sits on the host side of an asynchronous, byte-wide, one-time-programmable memory with an 18-bit address bus. A client presents a read request with an address. The sequencer drives the address, pulls the active-low chip-select and output-gate lines low, and waits a fixed number of clock cycles to cover the device's access time. It then samples the data bus and returns the byte together with a one-cycle valid strobe.

Both wait lengths come from parameters given in picoseconds. Each is rounded up to whole clock cycles. A full access, counted from an address change or from leaving standby, uses the long count. The short output-gate count applies only when the chip is still selected and the same address is read again. Between reads the output gate is released, so the data bus floats, but chip-select stays low. If no request arrives for a programmable number of cycles, chip-select is raised and the memory falls back to its low-power standby.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it, `mem_ce_n` and `mem_oe_n` are 1, `rd_valid` is 0 and `req_ready` is 1.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. From the next cycle, `mem_addr` equals the request address and both `mem_ce_n` and `mem_oe_n` are 0. `mem_oe_n` is never 0 while `mem_ce_n` is 1.
- R3: On the capture edge, the value on `mem_dq` is stored into `rd_data`, and `rd_valid` is 1 for exactly one cycle after it. `rd_data` then holds until the next capture.
- R4: The access count is ceil(T_ACC_PS / CLK_PS) and the gate count is ceil(T_OE_PS / CLK_PS). With the defaults these are 10 and 6. For a read started from standby, capture happens on the edge that comes access-count edges after the accept edge.
- R5: From the accept edge until the capture edge, `req_ready` is 0. Requests offered in that time are ignored and `mem_addr` stays stable.
- R6: The capture edge raises `mem_oe_n` and leaves `mem_ce_n` at 0.
- R7: If the chip is still selected and the next request has a different address, the wait is the access count and `mem_ce_n` stays 0 throughout.
- R8: If the chip is still selected and the next request has the same address as the last one, the wait is only the gate count.
- R9: If IDLE_CYC edges pass after a capture with no accepted request, `mem_ce_n` goes to 1. Any read after that waits the full access count, even one to the same address.
- R10: A request accepted on the edge where the idle limit would be reached takes priority over standby. `mem_ce_n` stays 0 and the same-address short wait applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | ADDR_W | Byte address to read |
| req_ready | output | 1 | Sequencer can accept a request |
| rd_data | output | DATA_W | Captured byte |
| rd_valid | output | 1 | One-cycle strobe marking new `rd_data` |
| mem_addr | output | ADDR_W | Address bus to the memory |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_oe_n | output | 1 | Active-low output gate |
| mem_dq | input | DATA_W | Data bus from the memory |

## Verification
The bench's memory model returns the correct byte only if the address, chip-select and output-gate have each been held long enough; otherwise it returns the bit-inverse. A wait count that is off by one edge therefore shows up as corrupted data as well as a wrong latency. The bench targets three cases in particular:
- a repeated address with the chip still selected, where a design that ignores the shortcut loses four cycles;
- a new address with the chip still selected, where taking the shortcut wrongly captures garbage;
- a request landing on the final idle cycle, where a design that lets standby win would drop chip-select and then pay the full wait.

It also offers a second request while a read is in flight; a design that does not gate requests during that time would switch addresses mid-access.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

  typedef enum logic [1:0] {
    ST_STANDBY = 2'd0,
    ST_OPEN    = 2'd1,
    ST_BUSY    = 2'd2
  } rd_state_e;

  // Whole clock cycles covering a delay, at least one.
  function automatic int cycles_for(input int t_ps, input int clk_ps);
    int c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/eprom_wait_timer.sv
module eprom_wait_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/eprom_idle_timer.sv
module eprom_idle_timer #(
  parameter int IDLE_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expire
);

  localparam int ICW = $clog2(IDLE_CYC + 1);
  localparam logic [ICW-1:0] LAST = ICW'(IDLE_CYC - 1);

  logic [ICW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expire = run && (cnt_q == LAST);

endmodule

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl
  import eprom_rd_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 8,
  parameter int CLK_PS   = 10000,
  parameter int T_ACC_PS = 100000,
  parameter int T_OE_PS  = 55000,
  parameter int IDLE_CYC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  input  logic [DATA_W-1:0] mem_dq
);

  localparam int ACC_CYC  = cycles_for(T_ACC_PS, CLK_PS);
  localparam int OE_CYC   = cycles_for(T_OE_PS, CLK_PS);
  localparam int WAIT_MAX = (ACC_CYC > OE_CYC) ? ACC_CYC : OE_CYC;
  localparam int WCW      = $clog2(WAIT_MAX + 1);
  localparam logic [WCW-1:0] ACC_LD = WCW'(ACC_CYC - 1);
  localparam logic [WCW-1:0] OE_LD  = WCW'(OE_CYC - 1);

  rd_state_e state_q, state_d;
  logic      accept, capture, same_addr;
  logic      wait_expired, idle_expire;
  logic [WCW-1:0] load_val;

  assign req_ready = (state_q != ST_BUSY);
  assign accept    = req_valid && req_ready;
  assign capture   = (state_q == ST_BUSY) && wait_expired;
  assign same_addr = (state_q == ST_OPEN) && (req_addr == mem_addr);

  // Short gate-only wait is worth selecting only if it is shorter.
  generate
    if (OE_CYC < ACC_CYC) begin : g_fast_path
      assign load_val = same_addr ? OE_LD : ACC_LD;
    end else begin : g_full_only
      assign load_val = ACC_LD;
    end
  endgenerate

  eprom_wait_timer #(.CW(WCW)) i_wait (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_val (load_val),
    .expired  (wait_expired)
  );

  eprom_idle_timer #(.IDLE_CYC(IDLE_CYC)) i_idle (
    .clk    (clk),
    .rst    (rst),
    .run    (state_q == ST_OPEN),
    .expire (idle_expire)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_STANDBY: if (accept) state_d = ST_BUSY;
      ST_OPEN: begin
        if (accept)           state_d = ST_BUSY;
        else if (idle_expire) state_d = ST_STANDBY;
      end
      ST_BUSY:    if (wait_expired) state_d = ST_OPEN;
      default:    state_d = ST_STANDBY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_STANDBY;
      mem_addr <= '0;
      mem_ce_n <= 1'b1;
      mem_oe_n <= 1'b1;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      state_q  <= state_d;
      mem_ce_n <= (state_d == ST_STANDBY);
      mem_oe_n <= (state_d != ST_BUSY);
      rd_valid <= capture;
      if (accept)  mem_addr <= req_addr;
      if (capture) rd_data  <= mem_dq;
    end
  end

endmodule

// File: rtl/eprom_rd_ctrl_chk.sv
module eprom_rd_ctrl_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_oe_n
);

  AST_OE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !mem_ce_n); // R2

  AST_ACCEPT_OPENS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!mem_ce_n && !mem_oe_n)); // R2

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid); // R3

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (!mem_oe_n && !$past(mem_oe_n)) |-> $stable(mem_addr)); // R5

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !req_ready); // R5

  AST_CAPTURE_CLOSES_GATE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (mem_oe_n && !mem_ce_n)); // R6

endmodule

bind eprom_rd_ctrl eprom_rd_ctrl_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rd_valid  (rd_valid),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_oe_n  (mem_oe_n)
);

// File: tb/test_eprom_rd_ctrl.sv
module test_eprom_rd_ctrl;

  localparam int CLK_PS = 10000;
  localparam int ACC    = (100000 + CLK_PS - 1) / CLK_PS; // 10
  localparam int OE     = (55000 + CLK_PS - 1) / CLK_PS;  // 6
  localparam int IDLE   = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [17:0] req_addr = '0;
  logic        req_ready, rd_valid, mem_ce_n, mem_oe_n;
  logic [7:0]  rd_data;
  logic [17:0] mem_addr;
  logic [7:0]  mem_dq = 8'h00;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #5 clk = ~clk;

  eprom_rd_ctrl i_eprom_rd_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .rd_data(rd_data), .rd_valid(rd_valid),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_dq(mem_dq)
  );

  function automatic logic [7:0] pattern(input logic [17:0] a);
    return a[7:0] ^ a[15:8] ^ {6'd0, a[17:16]};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Memory model: correct byte only after enough settled cycles.
  int          addr_age = 1000, ce_age = -1, oe_age = -1;
  logic [17:0] prev_addr = '0;

  // Reference model, advanced on every rising edge.
  int          m_mode = 0; // 0 standby, 1 selected, 2 reading
  int          m_rem = 0, m_idle = 0;
  logic [17:0] m_addr = '0;
  logic [7:0]  m_data = '0;
  bit          m_valid = 0;
  bit          started = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
    started = 1;
    if (rst) begin
      m_mode = 0; m_addr = '0; m_data = '0; m_valid = 0; m_idle = 0;
    end else begin
      m_valid = 0;
      if (m_mode == 2) begin
        m_rem--;
        if (m_rem == 0) begin
          m_valid = 1; m_data = mem_dq; m_mode = 1; m_idle = 0;
        end
      end else if (req_valid) begin
        m_rem  = (m_mode == 1 && req_addr == m_addr) ? OE : ACC;
        m_addr = req_addr;
        m_mode = 2;
      end else if (m_mode == 1) begin
        m_idle++;
        if (m_idle == IDLE) m_mode = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (mem_addr != prev_addr) addr_age = 0;
    else if (addr_age < 1000) addr_age++;
    prev_addr = mem_addr;
    if (mem_ce_n) ce_age = -1; else if (ce_age < 1000) ce_age++;
    if (mem_oe_n) oe_age = -1; else if (oe_age < 1000) oe_age++;
    if (addr_age >= ACC - 1 && ce_age >= ACC - 1 && oe_age >= OE - 1)
      mem_dq = pattern(mem_addr);
    else
      mem_dq = ~pattern(mem_addr);
    if (started) begin
      chk(mem_ce_n == (m_mode == 0), "R9", "ce_n", mem_ce_n, m_mode == 0);
      chk(mem_oe_n == (m_mode != 2), "R6", "oe_n", mem_oe_n, m_mode != 2);
      chk(req_ready == (m_mode != 2), "R5", "ready", req_ready, m_mode != 2);
      chk(rd_valid == m_valid, "R3", "rd_valid", rd_valid, m_valid);
      chk(rd_data == m_data, "R3", "rd_data", rd_data, m_data);
      chk(mem_addr == m_addr, "R2", "mem_addr", mem_addr, m_addr);
    end
  end

  // Issue a read at the current falling edge and wait for its strobe.
  task automatic do_read(input logic [17:0] a, output int lat,
                         output logic [7:0] d, output bit ce_hi);
    int n;
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    n = 1; ce_hi = 0;
    while (!rd_valid) begin
      ce_hi |= mem_ce_n;
      @(negedge clk);
      n++;
    end
    lat = n - 1;
    d = rd_data;
  endtask

  initial begin
    int lat; logic [7:0] d; bit hi;
    repeat (3) @(negedge clk);
    chk(mem_ce_n == 1 && mem_oe_n == 1, "R1", "enables in reset", {mem_ce_n, mem_oe_n}, 2'b11);
    chk(rd_valid == 0 && req_ready == 1, "R1", "valid/ready in reset", {rd_valid, req_ready}, 2'b01);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_ce_n == 1 && req_ready == 1, "R1", "after reset", {mem_ce_n, req_ready}, 2'b11);

    // R4: read from standby
    do_read(18'h1_2345, lat, d, hi);
    chk(lat == ACC, "R4", "standby latency", lat, ACC);
    chk(d == pattern(18'h1_2345), "R3", "data A", d, pattern(18'h1_2345));
    chk(mem_ce_n == 0 && mem_oe_n == 1, "R6", "after capture", {mem_ce_n, mem_oe_n}, 2'b01);

    // R7: new address, chip still selected
    do_read(18'h2_0F0F, lat, d, hi);
    chk(lat == ACC, "R7", "new-address latency", lat, ACC);
    chk(hi == 0, "R7", "ce stayed low", hi, 0);
    chk(d == pattern(18'h2_0F0F), "R7", "data B", d, pattern(18'h2_0F0F));

    // R8: same address again
    do_read(18'h2_0F0F, lat, d, hi);
    chk(lat == OE, "R8", "same-address latency", lat, OE);
    chk(d == pattern(18'h2_0F0F), "R8", "data B again", d, pattern(18'h2_0F0F));

    // R5: request offered while busy is ignored
    req_valid = 1'b1; req_addr = 18'h0_00AA;
    @(negedge clk);
    req_addr = 18'h3_1111;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(mem_addr == 18'h0_00AA, "R5", "addr held while busy", mem_addr, 18'h0_00AA);
      chk(req_ready == 0, "R5", "ready low while busy", req_ready, 0);
    end
    req_valid = 1'b0;
    lat = 4;
    while (!rd_valid) begin @(negedge clk); lat++; end
    lat--;
    chk(lat == ACC, "R5", "busy read latency", lat, ACC);
    chk(rd_data == pattern(18'h0_00AA), "R5", "data C", rd_data, pattern(18'h0_00AA));

    // R9: idle timeout
    repeat (IDLE - 1) @(negedge clk);
    chk(mem_ce_n == 0, "R9", "ce before limit", mem_ce_n, 0);
    @(negedge clk);
    chk(mem_ce_n == 1, "R9", "ce at limit", mem_ce_n, 1);
    do_read(18'h0_00AA, lat, d, hi);
    chk(lat == ACC, "R9", "same address after standby", lat, ACC);
    chk(d == pattern(18'h0_00AA), "R9", "data after standby", d, pattern(18'h0_00AA));

    // R10: request on the final idle cycle
    repeat (IDLE - 1) @(negedge clk);
    do_read(18'h0_00AA, lat, d, hi);
    chk(hi == 0, "R10", "ce stayed low", hi, 0);
    chk(lat == OE, "R10", "last-cycle latency", lat, OE);

    // Boundary addresses
    do_read(18'h3_FFFF, lat, d, hi);
    chk(lat == ACC && d == pattern(18'h3_FFFF), "R7", "top address", d, pattern(18'h3_FFFF));
    do_read(18'h0_0000, lat, d, hi);
    chk(lat == ACC && d == pattern(18'h0_0000), "R7", "zero address", d, pattern(18'h0_0000));

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule